// File: doc/BRIEF.md
# Dual-Port Address-Match Busy Arbiter

This block sits beside a two-port memory array and watches the enable and address of each port. When both ports select the same word in the same clock cycle, it lets one port continue and pulls the busy line of the other port low. The port that was already parked on the address keeps priority. When both ports arrive in the same cycle, a fixed rule gives the left port priority. Whether an access is a read or a write plays no part in the decision.

For each port the block also produces a write qualifier. This is the signal the array uses as its write strobe. A port that is busy never gets a write qualifier, whatever it drives on its read/write line. The busy indication and the qualifiers are combinational from the current inputs. A small registered state remembers each port's previous selection and the current owner of a continuing conflict.

Top module: `dp_busy_arbiter`

## Requirements
- R1: When either chip enable is high (deselected), or when the two addresses differ in any bit, the most significant bit included, both busy outputs are high in that same cycle.
- R2: A conflict is raised for two reads (read/write line high on both ports) to the same address, exactly as it is for writes.
- R3: A port that was selected at an address on the previous clock edge wins over a port that newly selects that address. The newcomer's busy output goes low in the same cycle it arrives. This also applies when the newcomer moves over from a different address.
- R4: When both ports reach the matching address in the same cycle, the left port wins and only the right busy output goes low. The two busy outputs are never low together.
- R5: The write qualifier of a port whose busy output is low stays low, even with that port's chip enable and read/write line both low.
- R6: While a conflict continues from one cycle to the next, the port that owns it keeps ownership and busy does not change sides.
- R7: Busy is released in the same cycle that the addresses stop matching or either chip enable goes high. The next conflict is arbitrated afresh.
- R8: While reset is low, both busy outputs are high even when the inputs match. After reset no port owns a conflict.
- R9: A port's write qualifier is high exactly when its chip enable and read/write line are both low and its busy output is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_l_n | input | 1 | Left port select, active low |
| we_l_n | input | 1 | Left port read/write, low = write |
| addr_l | input | ADDR_W | Left port word address |
| ce_r_n | input | 1 | Right port select, active low |
| we_r_n | input | 1 | Right port read/write, low = write |
| addr_r | input | ADDR_W | Right port word address |
| busy_l_n | output | 1 | Left port busy, active low |
| busy_r_n | output | 1 | Right port busy, active low |
| wr_en_l | output | 1 | Left write qualifier to the array |
| wr_en_r | output | 1 | Right write qualifier to the array |

## Verification
The bench builds the block with the default 11-bit address. This puts the all-ones word and addresses that differ only in the top bit within reach, so the full width of the comparator is exercised. Sequences of one or more cycles cover a port that arrives first, a port that moves onto an occupied address, a same-cycle tie, and a release followed by a fresh arbitration. Outputs are sampled after the inputs settle, before the next edge.

// File: rtl/dp_busy_arbiter.sv
module dp_busy_arbiter #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_l_n,
  input  logic              we_l_n,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic              ce_r_n,
  input  logic              we_r_n,
  input  logic [ADDR_W-1:0] addr_r,
  output logic              busy_l_n,
  output logic              busy_r_n,
  output logic              wr_en_l,
  output logic              wr_en_r
);

  logic              sel_l, sel_r;
  logic              held_l_q, held_r_q;
  logic [ADDR_W-1:0] addr_l_q, addr_r_q;
  logic              own_l_q, own_r_q;
  logic              steady_l, steady_r;
  logic              conflict, left_wins;

  assign sel_l = ~ce_l_n;
  assign sel_r = ~ce_r_n;

  // a port is steady when it was selected at the same word on the last edge
  assign steady_l = sel_l & held_l_q & (addr_l_q == addr_l);
  assign steady_r = sel_r & held_r_q & (addr_r_q == addr_r);

  assign conflict  = rst_n & sel_l & sel_r & (addr_l == addr_r);
  assign left_wins = own_l_q | (~own_r_q & ~(steady_r & ~steady_l));

  assign busy_l_n = ~(conflict & ~left_wins);
  assign busy_r_n = ~(conflict & left_wins);

  assign wr_en_l = sel_l & ~we_l_n & busy_l_n;
  assign wr_en_r = sel_r & ~we_r_n & busy_r_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_l_q <= 1'b0;
      held_r_q <= 1'b0;
      addr_l_q <= '0;
      addr_r_q <= '0;
      own_l_q  <= 1'b0;
      own_r_q  <= 1'b0;
    end else begin
      held_l_q <= sel_l;
      held_r_q <= sel_r;
      addr_l_q <= addr_l;
      addr_r_q <= addr_r;
      own_l_q  <= conflict & left_wins;
      own_r_q  <= conflict & ~left_wins;
    end
  end

  a_r1_idle_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_l_n || ce_r_n || addr_l != addr_r) |-> (busy_l_n && busy_r_n));

  a_r4_one_side_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_l_n && !ce_r_n && addr_l == addr_r) |-> ($countones({busy_l_n, busy_r_n}) == 1));

  a_r3_parked_left_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(conflict) && $past(!ce_l_n) && $past(addr_l) == addr_l
       && !($past(!ce_r_n) && $past(addr_r) == addr_r)) |-> !busy_r_n);

  a_r6_left_owner_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict && $past(conflict) && $past(!busy_r_n)) |-> !busy_r_n);

  a_r6_right_owner_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict && $past(conflict) && $past(!busy_l_n)) |-> !busy_l_n);

  a_r5_busy_left_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_l_n) |-> !wr_en_l);

  a_r5_busy_right_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_r_n) |-> !wr_en_r);

endmodule

// File: tb/dp_busy_arbiter_tb.sv
module dp_busy_arbiter_tb;
  localparam int AW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_l_n = 1'b1, we_l_n = 1'b1, ce_r_n = 1'b1, we_r_n = 1'b1;
  logic [AW-1:0] addr_l = '0, addr_r = '0;
  logic busy_l_n, busy_r_n, wr_en_l, wr_en_r;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dp_busy_arbiter #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ce_l_n(ce_l_n), .we_l_n(we_l_n), .addr_l(addr_l),
    .ce_r_n(ce_r_n), .we_r_n(we_r_n), .addr_r(addr_r),
    .busy_l_n(busy_l_n), .busy_r_n(busy_r_n),
    .wr_en_l(wr_en_l), .wr_en_r(wr_en_r)
  );

  task automatic expect_out(input string tag, input logic bl, input logic br,
                            input logic wl, input logic wr);
    checks++;
    if ({busy_l_n, busy_r_n, wr_en_l, wr_en_r} !== {bl, br, wl, wr}) begin
      errors++;
      $display("FAIL %s: busy_l_n/busy_r_n/wr_en_l/wr_en_r got %b%b%b%b expected %b%b%b%b",
               tag, busy_l_n, busy_r_n, wr_en_l, wr_en_r, bl, br, wl, wr);
    end
  endtask

  // drive after the falling edge, sample 1 ns later, well before the next rising edge
  task automatic drive(input logic cl, input logic wl, input logic [AW-1:0] al,
                       input logic cr, input logic wr, input logic [AW-1:0] ar);
    @(negedge clk);
    ce_l_n = cl; we_l_n = wl; addr_l = al;
    ce_r_n = cr; we_r_n = wr; addr_r = ar;
    #1;
  endtask

  task automatic t_reset;
    drive(0, 0, 11'h009, 0, 0, 11'h009);
    expect_out("R8 busy high in reset", 1, 1, 1, 1);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1, 1, 0, 1, 1, 0);
    expect_out("R8 idle after reset", 1, 1, 0, 0);
  endtask

  task automatic t_no_conflict;
    drive(0, 0, 11'h003, 0, 0, 11'h004);
    expect_out("R9 independent writes", 1, 1, 1, 1);
    drive(0, 0, 11'h0AA, 0, 0, 11'h4AA);
    expect_out("R1 differ in msb only", 1, 1, 1, 1);
    drive(0, 0, 11'h0AA, 1, 0, 11'h0AA);
    expect_out("R1 right deselected", 1, 1, 1, 0);
    drive(1, 1, 0, 1, 1, 0);
  endtask

  task automatic t_left_first;
    drive(0, 1, 11'h155, 1, 1, 11'h000);
    expect_out("R3 left alone", 1, 1, 0, 0);
    drive(0, 1, 11'h155, 0, 0, 11'h155);
    expect_out("R3 R5 right arrives late", 1, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      drive(0, 0, 11'h155, 0, 0, 11'h155);
      expect_out("R6 left keeps ownership", 1, 0, 1, 0);
    end
    drive(0, 0, 11'h155, 1, 0, 11'h155);
    expect_out("R7 right deselects", 1, 1, 1, 0);
  endtask

  task automatic t_right_first;
    drive(1, 1, 0, 0, 1, 11'h2C3);
    expect_out("R3 right alone", 1, 1, 0, 0);
    drive(0, 0, 11'h2C3, 0, 1, 11'h2C3);
    expect_out("R3 R5 left arrives late", 0, 1, 0, 0);
    drive(0, 0, 11'h2C3, 0, 0, 11'h2C3);
    expect_out("R6 R9 right keeps ownership", 0, 1, 0, 1);
    drive(0, 0, 11'h2C4, 0, 0, 11'h2C3);
    expect_out("R7 address moves away", 1, 1, 1, 1);
    drive(1, 1, 0, 1, 1, 0);
  endtask

  task automatic t_tie_reads;
    drive(0, 1, 11'h7FF, 0, 1, 11'h7FF);
    expect_out("R2 R4 tie on reads, left wins", 1, 0, 0, 0);
    drive(0, 1, 11'h7FF, 0, 0, 11'h7FF);
    expect_out("R5 R6 busy right write gated", 1, 0, 0, 0);
    drive(1, 1, 11'h7FF, 0, 0, 11'h7FF);
    expect_out("R7 left deselects", 1, 1, 0, 1);
  endtask

  task automatic t_move_in;
    drive(0, 1, 11'h010, 0, 1, 11'h020);
    expect_out("R1 distinct words", 1, 1, 0, 0);
    drive(0, 0, 11'h020, 0, 0, 11'h020);
    expect_out("R3 left moves onto parked right", 0, 1, 0, 1);
    drive(0, 0, 11'h020, 0, 0, 11'h020);
    expect_out("R6 right still owns", 0, 1, 0, 1);
    drive(1, 1, 0, 1, 1, 0);
    drive(0, 1, 11'h020, 0, 1, 11'h020);
    expect_out("R7 rearbitrated tie", 1, 0, 0, 0);
    drive(1, 1, 0, 1, 1, 0);
    expect_out("R1 both idle", 1, 1, 0, 0);
  endtask

  initial begin
    t_reset();
    t_no_conflict();
    t_left_first();
    t_right_first();
    t_tie_reads();
    t_move_in();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule